// File: doc/BRIEF.md
# VBI Data Window Controller

This block sits in a display output pipeline. It decides on which pixels vertical-blank-interval data replaces normal graphics, and from which memory offset the fetch engine should start reading that data for the current field. A CPU-side register port programs three configuration words: a primary word with an enable flag and the even-field offset, a word with the odd-field offset, and a word with the horizontal window bounds.

Every configuration write lands in a shadow copy that can be read back at once. The whole shadow set is copied into the working set in one step when the timing generator signals the start of a frame, or of a field in interlaced mode. On that same boundary the fetch-start address is latched. It takes the odd offset for an odd interlaced field and the even offset in every other case. Within the field, a per-pixel strobe marks the window. While the strobe is high, the output mux passes the raw VBI data word without change, and the graphics word otherwise.

The horizontal bounds are held as position minus one. The window therefore covers pixel columns start+1 through end+1, both inclusive, on lines the timing generator flags as VBI lines.

Top module: `vbi_window_ctrl`

## Requirements
- R1: A configuration write changes only the shadow copy. It is visible at once on `cfg_rdata`, but `vbi_active`, `vbi_sel`, `pix_out` and `fetch_addr` keep following the old working set until a `field_start` pulse.
- R2: On a clock edge with `field_start` high, all three working values (enable, offsets, horizontal bounds) take the shadow values held before that edge. A write in the same cycle reaches the working set only at the next boundary.
- R3: The enable is bit 28 of the primary word (`cfg_sel` = 0). With the working enable clear, `vbi_active` and `vbi_sel` stay low and `pix_out` equals `gfx_data`.
- R4: The even offset is bits 27:0 of the primary word and the odd offset is bits 27:0 of the odd word (`cfg_sel` = 1). Bits 2:0 of both offsets read back as zero, and `fetch_addr[2:0]` is always zero, whatever was written.
- R5: On a `field_start` edge, `fetch_addr` loads the shadow odd offset when both `interlace_en` and `field_odd` are high, and the shadow even offset otherwise.
- R6: The horizontal word (`cfg_sel` = 2) holds the start in bits 11:0 and the end in bits 27:16. `vbi_active` is high exactly when the working enable is set, `line_in_vbi` is high, and start+1 <= `pix_x` <= end+1.
- R7: `vbi_sel` equals `vbi_active`. `pix_out` equals `vbi_data` bit for bit while it is high, and `gfx_data` otherwise.
- R8: Bits 31:29 of the primary word, bits 31:28 of the odd and horizontal words, bits 15:12 of the horizontal word, and any read with `cfg_sel` = 3 return zero. A write with `cfg_sel` = 3 changes nothing.
- R9: After reset, the shadow and working values are zero, `fetch_addr` is zero and `vbi_active` is low.
- R10: `fetch_addr` changes only on a clock edge with `field_start` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word select: 0 primary/even, 1 odd, 2 horizontal, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Shadow readback of the selected word |
| field_start | input | 1 | One-cycle pulse at the start of a frame or field |
| field_odd | input | 1 | Parity of the field that is starting (1 = odd) |
| interlace_en | input | 1 | Interlaced output mode |
| line_in_vbi | input | 1 | Current line lies in the VBI line range |
| pix_x | input | 12 | Current horizontal pixel position |
| gfx_data | input | 24 | Normal graphics pixel word |
| vbi_data | input | 24 | Raw VBI data word |
| pix_out | output | 24 | Muxed pixel word |
| vbi_active | output | 1 | Pixel lies inside the VBI window |
| vbi_sel | output | 1 | Mux select, high while VBI data is passed |
| fetch_addr | output | 28 | Fetch-start offset latched for the current field |

## Verification
The horizontal compare is swept column by column across programmed windows, including a window that starts at column 1 and one whose end is at the top of the counter range. This separates an off-by-one in the minus-one encoding from a missing inclusive bound. Field boundaries are tried with every combination of `interlace_en` and `field_odd`, which separates the parity-based offset choice from a plain odd/even toggle. Writes placed before, on, and after a `field_start` edge show whether staging and the one-step commit keep to the boundary. A long stretch of mixed random writes, boundaries and pixel traffic is then compared every cycle against a behavioural model.

// File: rtl/vbi_pkg.sv
package vbi_pkg;

    localparam int unsigned CFG_W   = 32;
    localparam int unsigned OFF_W   = 28;
    localparam int unsigned PIX_W   = 12;
    localparam int unsigned ALIGN_W = 3;
    localparam int unsigned EN_BIT  = 28;
    localparam int unsigned HEND_LO = 16;

    typedef enum logic [1:0] {
        SEL_MAIN = 2'd0,
        SEL_ODD  = 2'd1,
        SEL_HWIN = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic             en;
        logic [OFF_W-1:0] even_off;
        logic [OFF_W-1:0] odd_off;
        logic [PIX_W-1:0] h_start;
        logic [PIX_W-1:0] h_end;
    } vbi_cfg_t;

    function automatic logic [OFF_W-1:0] align_off(input logic [OFF_W-1:0] raw);
        return {raw[OFF_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/vbi_addr_sel.sv
module vbi_addr_sel
    import vbi_pkg::*;
(
    input  logic [OFF_W-1:0] even_off,
    input  logic [OFF_W-1:0] odd_off,
    input  logic             field_odd,
    input  logic             interlace_en,
    output logic [OFF_W-1:0] sel_off
);

    logic use_odd;

    always_comb begin
        use_odd = interlace_en & field_odd;
        sel_off = use_odd ? odd_off : even_off;
    end

endmodule

// File: rtl/vbi_cfg_regs.sv
module vbi_cfg_regs
    import vbi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             field_start,
    input  logic             field_odd,
    input  logic             interlace_en,
    output vbi_cfg_t         act_cfg,
    output logic [OFF_W-1:0] fetch_addr
);

    localparam int unsigned HEND_HI = HEND_LO + PIX_W - 1;

    typedef struct packed {
        vbi_cfg_t         shadow;
        vbi_cfg_t         active;
        logic [OFF_W-1:0] fetch;
    } regs_t;

    regs_t            st_d, st_q;
    logic [OFF_W-1:0] commit_off;
    cfg_sel_e         sel;

    assign sel = cfg_sel_e'(cfg_sel);

    vbi_addr_sel u_addr_sel (
        .even_off     (st_q.shadow.even_off),
        .odd_off      (st_q.shadow.odd_off),
        .field_odd    (field_odd),
        .interlace_en (interlace_en),
        .sel_off      (commit_off)
    );

    always_comb begin
        st_d = st_q;
        if (field_start) begin
            st_d.active = st_q.shadow;
            st_d.fetch  = commit_off;
        end
        if (cfg_we) begin
            unique case (sel)
                SEL_MAIN: begin
                    st_d.shadow.en       = cfg_wdata[EN_BIT];
                    st_d.shadow.even_off = align_off(cfg_wdata[OFF_W-1:0]);
                end
                SEL_ODD: begin
                    st_d.shadow.odd_off  = align_off(cfg_wdata[OFF_W-1:0]);
                end
                SEL_HWIN: begin
                    st_d.shadow.h_start  = cfg_wdata[PIX_W-1:0];
                    st_d.shadow.h_end    = cfg_wdata[HEND_HI:HEND_LO];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (sel)
            SEL_MAIN: begin
                cfg_rdata[EN_BIT]      = st_q.shadow.en;
                cfg_rdata[OFF_W-1:0]   = st_q.shadow.even_off;
            end
            SEL_ODD: begin
                cfg_rdata[OFF_W-1:0]   = st_q.shadow.odd_off;
            end
            SEL_HWIN: begin
                cfg_rdata[PIX_W-1:0]       = st_q.shadow.h_start;
                cfg_rdata[HEND_HI:HEND_LO] = st_q.shadow.h_end;
            end
            default: ;
        endcase
    end

    assign act_cfg    = st_q.active;
    assign fetch_addr = st_q.fetch;

    // R10
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(fetch_addr));

    // R1
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(act_cfg));

    // R4
    fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr[ALIGN_W-1:0] == '0);

endmodule

// File: rtl/vbi_hwin.sv
module vbi_hwin
    import vbi_pkg::*;
#(
    parameter int unsigned DATA_W = 24
) (
    input  vbi_cfg_t          act_cfg,
    input  logic              line_in_vbi,
    input  logic [PIX_W-1:0]  pix_x,
    input  logic [DATA_W-1:0] gfx_data,
    input  logic [DATA_W-1:0] vbi_data,
    output logic              win_on,
    output logic [DATA_W-1:0] pix_out
);

    localparam int unsigned CMP_W = PIX_W + 1;

    logic [CMP_W-1:0] x_ext, lo_bound, hi_bound;
    logic             after_lo, before_hi;

    always_comb begin
        x_ext     = {1'b0, pix_x};
        lo_bound  = {1'b0, act_cfg.h_start} + CMP_W'(1);
        hi_bound  = {1'b0, act_cfg.h_end} + CMP_W'(1);
        after_lo  = x_ext >= lo_bound;
        before_hi = x_ext <= hi_bound;
        win_on    = act_cfg.en & line_in_vbi & after_lo & before_hi;
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
        assign pix_out[b] = win_on ? vbi_data[b] : gfx_data[b];
    end

endmodule

// File: rtl/vbi_window_ctrl.sv
module vbi_window_ctrl
    import vbi_pkg::*;
#(
    parameter int unsigned DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              field_start,
    input  logic              field_odd,
    input  logic              interlace_en,
    input  logic              line_in_vbi,
    input  logic [11:0]       pix_x,
    input  logic [DATA_W-1:0] gfx_data,
    input  logic [DATA_W-1:0] vbi_data,
    output logic [DATA_W-1:0] pix_out,
    output logic              vbi_active,
    output logic              vbi_sel,
    output logic [27:0]       fetch_addr
);

    vbi_cfg_t act_cfg;
    logic     win_on;

    vbi_cfg_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .field_start  (field_start),
        .field_odd    (field_odd),
        .interlace_en (interlace_en),
        .act_cfg      (act_cfg),
        .fetch_addr   (fetch_addr)
    );

    vbi_hwin #(.DATA_W(DATA_W)) u_hwin (
        .act_cfg     (act_cfg),
        .line_in_vbi (line_in_vbi),
        .pix_x       (pix_x),
        .gfx_data    (gfx_data),
        .vbi_data    (vbi_data),
        .win_on      (win_on),
        .pix_out     (pix_out)
    );

    assign vbi_active = win_on;
    assign vbi_sel    = win_on;

    // R7
    pass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vbi_sel |-> (pix_out == vbi_data));

    // R6
    line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vbi_active |-> line_in_vbi);

    // R8
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 2'd3) |-> (cfg_rdata == 32'd0));

    // R4
    rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel != 2'd2) |-> (cfg_rdata[2:0] == 3'd0));

endmodule

// File: tb/test_vbi_window_ctrl.sv
module test_vbi_window_ctrl;

    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [1:0]    cfg_sel;
    logic [31:0]   cfg_wdata;
    logic [31:0]   cfg_rdata;
    logic          field_start, field_odd, interlace_en, line_in_vbi;
    logic [11:0]   pix_x;
    logic [DW-1:0] gfx_data, vbi_data, pix_out;
    logic          vbi_active, vbi_sel;
    logic [27:0]   fetch_addr;

    int errors = 0;
    int checks = 0;

    // behavioural model state
    int unsigned m_sh[3];
    int unsigned m_act[3];
    int unsigned m_fetch;

    always #5 clk = ~clk;

    vbi_window_ctrl #(.DATA_W(DW)) i_vbi_window_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .field_start(field_start),
        .field_odd(field_odd), .interlace_en(interlace_en), .line_in_vbi(line_in_vbi),
        .pix_x(pix_x), .gfx_data(gfx_data), .vbi_data(vbi_data), .pix_out(pix_out),
        .vbi_active(vbi_active), .vbi_sel(vbi_sel), .fetch_addr(fetch_addr)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_win();
        int hs, he, x;
        hs = int'(m_act[2] & 32'hFFF);
        he = int'((m_act[2] >> 16) & 32'hFFF);
        x  = int'(pix_x);
        return ((m_act[0] >> 28) & 1) == 1 && line_in_vbi && x >= hs + 1 && x <= he + 1;
    endfunction

    function automatic int unsigned m_rd();
        if (cfg_sel == 2'd3) return 0;
        return m_sh[cfg_sel];
    endfunction

    task automatic compare_all();
        bit w;
        w = m_win();
        chk("R6 vbi_active", longint'(vbi_active), longint'(w));
        chk("R7 vbi_sel", longint'(vbi_sel), longint'(w));
        chk("R7 pix_out", longint'(pix_out), w ? longint'(vbi_data) : longint'(gfx_data));
        chk("R5 fetch_addr", longint'(fetch_addr), longint'(m_fetch));
        chk("R8 cfg_rdata", longint'(cfg_rdata), longint'(m_rd()));
    endtask

    task automatic model_edge();
        int unsigned old_sh[3];
        for (int i = 0; i < 3; i++) old_sh[i] = m_sh[i];
        if (field_start) begin
            for (int i = 0; i < 3; i++) m_act[i] = old_sh[i];
            m_fetch = (interlace_en && field_odd) ? (old_sh[1] & 32'h0FFF_FFFF)
                                                  : (old_sh[0] & 32'h0FFF_FFFF);
        end
        if (cfg_we) begin
            case (cfg_sel)
                2'd0: m_sh[0] = cfg_wdata & 32'h1FFF_FFF8;
                2'd1: m_sh[1] = cfg_wdata & 32'h0FFF_FFF8;
                2'd2: m_sh[2] = cfg_wdata & 32'h0FFF_0FFF;
                default: ;
            endcase
        end
    endtask

    // inputs already driven; compare, advance one edge, return at negedge
    task automatic cyc();
        #1 compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle_in();
        cfg_we = 0; cfg_sel = 2'd3; cfg_wdata = '0; field_start = 0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        cfg_we = 1; cfg_sel = s; cfg_wdata = d; field_start = 0;
        cyc();
        idle_in();
    endtask

    task automatic boundary(input logic il, input logic odd);
        interlace_en = il; field_odd = odd; field_start = 1;
        cyc();
        field_start = 0;
    endtask

    task automatic readback(input logic [1:0] s, input logic [31:0] exp, input string req);
        cfg_sel = s; #1;
        chk(req, longint'(cfg_rdata), longint'(exp));
    endtask

    task automatic sweep(input int lo, input int hi);
        line_in_vbi = 1;
        for (int x = lo; x <= hi; x++) begin
            pix_x = 12'(x);
            gfx_data = DW'(x * 37);
            vbi_data = DW'(~(x * 91));
            cyc();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin m_sh[i] = 0; m_act[i] = 0; end
        m_fetch = 0;
        rst_n = 0; idle_in();
        field_odd = 0; interlace_en = 0; line_in_vbi = 0; pix_x = '0;
        gfx_data = '0; vbi_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R9: reset state
        readback(2'd0, 32'h0, "R9 main after reset");
        readback(2'd2, 32'h0, "R9 hwin after reset");
        line_in_vbi = 1; pix_x = 12'd1; #1;
        chk("R9 vbi_active after reset", longint'(vbi_active), 0);
        chk("R9 fetch_addr after reset", longint'(fetch_addr), 0);
        cyc();

        // program: window 10..20, even off with low bits set, odd off
        wr(2'd2, 32'h0013_0009);
        wr(2'd0, 32'h1123_4567);
        wr(2'd1, 32'hF0AB_CDEF);
        // R4 / R8: alignment and reserved bits in readback
        readback(2'd0, 32'h1123_4560, "R4 even off readback aligned");
        readback(2'd1, 32'h00AB_CDE8, "R4 odd off readback aligned");
        readback(2'd2, 32'h0013_0009, "R1 hwin shadow visible");
        // R1: not yet in effect
        line_in_vbi = 1; pix_x = 12'd15; #1;
        chk("R1 staged write no effect", longint'(vbi_active), 0);
        chk("R1 fetch unchanged before boundary", longint'(fetch_addr), 0);
        cyc();

        // R2 / R5: commit, progressive -> even offset
        boundary(1'b0, 1'b1);
        chk("R5 progressive odd uses even", longint'(fetch_addr), 28'h123_4560);
        pix_x = 12'd15; #1;
        chk("R2 committed window active", longint'(vbi_active), 1);
        sweep(0, 30);
        pix_x = 12'd9; #1;  chk("R6 col start not in window", longint'(vbi_active), 0);
        pix_x = 12'd10; #1; chk("R6 col start+1 in window", longint'(vbi_active), 1);
        pix_x = 12'd20; #1; chk("R6 col end+1 in window", longint'(vbi_active), 1);
        pix_x = 12'd21; #1; chk("R6 col end+2 out", longint'(vbi_active), 0);
        line_in_vbi = 0; pix_x = 12'd15; #1;
        chk("R6 non-vbi line gated", longint'(vbi_active), 0);
        cyc();

        // R5 parity combinations
        boundary(1'b1, 1'b1);
        chk("R5 interlaced odd uses odd", longint'(fetch_addr), 28'hABC_DE8);
        boundary(1'b1, 1'b0);
        chk("R5 interlaced even uses even", longint'(fetch_addr), 28'h123_4560);
        boundary(1'b0, 1'b0);
        chk("R5 progressive even uses even", longint'(fetch_addr), 28'h123_4560);

        // R2: write on boundary edge is not committed
        cfg_we = 1; cfg_sel = 2'd2; cfg_wdata = 32'h0005_0000;
        interlace_en = 0; field_odd = 0; field_start = 1;
        cyc();
        idle_in();
        line_in_vbi = 1; pix_x = 12'd3; #1;
        chk("R2 same-edge write deferred", longint'(vbi_active), 0);
        cyc();
        boundary(1'b0, 1'b0);
        pix_x = 12'd1; #1;
        chk("R2 deferred write now active col1", longint'(vbi_active), 1);
        sweep(0, 8);

        // top-of-range window
        wr(2'd2, 32'h0FFE_0FF0);
        boundary(1'b0, 1'b0);
        sweep(4080, 4095);

        // R3: disable
        wr(2'd0, 32'h0123_4560);
        pix_x = 12'd4090; line_in_vbi = 1; #1;
        chk("R1 disable staged still active", longint'(vbi_active), 1);
        cyc();
        boundary(1'b0, 1'b0);
        pix_x = 12'd4090; #1;
        chk("R3 disabled no window", longint'(vbi_active), 0);
        chk("R3 disabled pix_out gfx", longint'(pix_out), longint'(gfx_data));
        sweep(4080, 4095);

        // R8: reserved bits ignore writes, sel 3 writes ignored
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'hFFFF_FFFF);
        readback(2'd0, 32'h1FFF_FFF8, "R8 main reserved zero");
        readback(2'd1, 32'h0FFF_FFF8, "R8 odd reserved zero");
        readback(2'd2, 32'h0FFF_0FFF, "R8 hwin reserved zero");
        wr(2'd3, 32'h0000_0000);
        readback(2'd0, 32'h1FFF_FFF8, "R8 sel3 write ignored");
        readback(2'd3, 32'h0, "R8 sel3 reads zero");
        cyc();

        // random traffic compared every cycle
        for (int n = 0; n < 3000; n++) begin
            cfg_we       = ($urandom % 8) == 0;
            cfg_sel      = 2'($urandom);
            cfg_wdata    = $urandom;
            if (cfg_sel == 2'd2) cfg_wdata = cfg_wdata & 32'hF03F_F03F;
            field_start  = ($urandom % 40) == 0;
            field_odd    = 1'($urandom);
            interlace_en = 1'($urandom);
            line_in_vbi  = ($urandom % 4) != 0;
            pix_x        = 12'($urandom % 80);
            gfx_data     = DW'($urandom);
            vbi_data     = DW'($urandom);
            cyc();
        end
        idle_in();
        cyc();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule